// File: doc/BRIEF.md
# Exception Acceptance Gate

This block sits next to a CPU instruction decoder. On every cycle in which the decoder presents a valid instruction, it decides whether a waiting address error or a waiting interrupt may be taken at that instruction. Two instruction classes leave a one-decode shadow behind them:

- A branch with a delay slot blocks both exception kinds for the slot instruction that follows it. This keeps the branch and its slot together.
- A transfer to or from a control or system register blocks only interrupts for the next decode.

An address error that cannot be taken at once is latched and kept until it is taken. An interrupt stays pending only while its requester holds the request. When both are acceptable in the same cycle, the address error wins and the interrupt waits. The decoder supplies a two-bit class code with each decode. The block returns single-cycle "take" pulses, the level of a taken interrupt, pending status, and a fault pulse when a delayed branch is found in a delay slot.

Top module: `exc_accept_gate`

## Requirements
- R1: A synchronous active-high `rst` clears every output, both pending flags and the blocking state. The first valid decode after reset is therefore unblocked.
- R2: A valid decode that directly follows a valid decode of class 1 (delayed branch) takes neither an address error nor an interrupt.
- R3: A valid decode that directly follows a valid decode of class 2 (control/system register transfer) takes no interrupt, but does take an available address error.
- R4: An address error request that is not taken is latched. `aerr_pending` stays 1 until a later valid decode takes it.
- R5: The interrupt request is level-sensitive. When `irq_req` falls before acceptance, `irq_pending` goes to 0 and no interrupt is taken for it.
- R6: When an address error and an interrupt are both acceptable at one decode, only `take_aerr` pulses, and `irq_pending` stays 1.
- R7: `take_aerr` and `take_irq` are one-cycle pulses, registered one clock after a decode with `dec_valid`=1. Cycles with `dec_valid`=0 take nothing and leave the blocking state unchanged.
- R8: A class-1 decode inside a delay slot pulses `slot_fault` one clock later and does not open a new slot. The next decode is unblocked.
- R9: `take_level` equals the `irq_level` present at the accepted decode while `take_irq` is 1, and is 0 otherwise.
- R10: A decode at which an exception is taken leaves no blocking shadow, whatever its class. Class codes 0 and 3 are normal instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | An instruction is decoded this cycle |
| dec_class | input | 2 | 0/3 normal, 1 delayed branch, 2 register transfer |
| aerr_req | input | 1 | Address error request |
| irq_req | input | 1 | Interrupt request (level) |
| irq_level | input | LVL_W | Level of the requesting interrupt |
| take_aerr | output | 1 | Address error accepted (pulse) |
| take_irq | output | 1 | Interrupt accepted (pulse) |
| take_level | output | LVL_W | Level of the accepted interrupt |
| aerr_pending | output | 1 | An address error is latched and waiting |
| irq_pending | output | 1 | An interrupt is requested and waiting |
| slot_fault | output | 1 | Delayed branch seen in a delay slot (pulse) |

## Verification
The assertions assume that `dec_class` is meaningful only when `dec_valid` is 1. They also assume that the decode shadow is tracked solely from decodes with `dec_valid`=1, so idle cycles between an instruction and its successor do not disturb the window. The stimulus changes inputs only away from the active edge. It holds every decode to a single cycle and checks each response one clock later. Idle cycles are inserted inside blocking windows on purpose, so that the window can be seen surviving them.

// File: rtl/exc_gate_pkg.sv
package exc_gate_pkg;
  localparam int CLS_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_NORMAL = 2'd0,
    CLS_DBR    = 2'd1,
    CLS_REGXF  = 2'd2,
    CLS_RSVD   = 2'd3
  } dec_cls_t;

  typedef enum logic [1:0] {
    BLK_NONE  = 2'd0,
    BLK_SLOT  = 2'd1,
    BLK_NOIRQ = 2'd2
  } blk_t;
endpackage

// File: rtl/exc_pend_latch.sv
module exc_pend_latch #(
  parameter bit STICKY = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic take,
  output logic pend,
  output logic avail
);
  generate
    if (STICKY) begin : g_sticky
      always_ff @(posedge clk) begin
        if (rst) pend <= 1'b0;
        else     pend <= (pend | req) & ~take;
      end
      assign avail = pend | req;

      // R4: a latched request survives until taken
      a_r4_held_until_taken: assert property (@(posedge clk) disable iff (rst)
        (pend && !take) |=> pend);
    end else begin : g_level
      always_ff @(posedge clk) begin
        if (rst) pend <= 1'b0;
        else     pend <= req & ~take;
      end
      assign avail = req;

      // R5: a withdrawn request does not stay pending
      a_r5_drop_on_release: assert property (@(posedge clk) disable iff (rst)
        !req |=> !pend);
    end
  endgenerate
endmodule

// File: rtl/exc_block_tracker.sv
module exc_block_tracker
  import exc_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             dec_valid,
  input  logic [CLS_W-1:0] dec_class,
  input  logic             taken,
  output blk_t             blk,
  output logic             slot_fault
);
  logic is_dbr;
  assign is_dbr = (dec_class == CLS_DBR);

  always_ff @(posedge clk) begin
    if (rst) begin
      blk        <= BLK_NONE;
      slot_fault <= 1'b0;
    end else begin
      slot_fault <= dec_valid & is_dbr & (blk == BLK_SLOT);
      if (dec_valid) begin
        if (taken) begin
          blk <= BLK_NONE;
        end else begin
          case (dec_class)
            CLS_DBR:   blk <= (blk == BLK_SLOT) ? BLK_NONE : BLK_SLOT;
            CLS_REGXF: blk <= BLK_NOIRQ;
            default:   blk <= BLK_NONE;
          endcase
        end
      end
    end
  end

  // R8: a branch inside a slot never opens another slot
  a_r8_no_nested_slot: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && blk == BLK_SLOT) |=> (blk != BLK_SLOT));
  // R7: idle cycles keep the window
  a_r7_idle_keeps_window: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |=> $stable(blk));
endmodule

// File: rtl/exc_accept_gate.sv
module exc_accept_gate
  import exc_gate_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dec_valid,
  input  logic [CLS_W-1:0] dec_class,
  input  logic             aerr_req,
  input  logic             irq_req,
  input  logic [LVL_W-1:0] irq_level,
  output logic             take_aerr,
  output logic             take_irq,
  output logic [LVL_W-1:0] take_level,
  output logic             aerr_pending,
  output logic             irq_pending,
  output logic             slot_fault
);
  blk_t blk;
  logic aerr_av, irq_av;
  logic take_a_n, take_i_n;

  exc_pend_latch #(.STICKY(1'b1)) u_aerr (
    .clk(clk), .rst(rst), .req(aerr_req), .take(take_a_n),
    .pend(aerr_pending), .avail(aerr_av)
  );

  exc_pend_latch #(.STICKY(1'b0)) u_irq (
    .clk(clk), .rst(rst), .req(irq_req), .take(take_i_n),
    .pend(irq_pending), .avail(irq_av)
  );

  exc_block_tracker u_blk (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_class(dec_class),
    .taken(take_a_n | take_i_n), .blk(blk), .slot_fault(slot_fault)
  );

  // address error is blocked only by a delay slot; interrupt by any shadow
  assign take_a_n = dec_valid & aerr_av & (blk != BLK_SLOT);
  assign take_i_n = dec_valid & irq_av & (blk == BLK_NONE) & ~take_a_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      take_aerr  <= 1'b0;
      take_irq   <= 1'b0;
      take_level <= '0;
    end else begin
      take_aerr  <= take_a_n;
      take_irq   <= take_i_n;
      take_level <= take_i_n ? irq_level : '0;
    end
  end

  // R2: nothing is taken in a delay slot
  a_r2_slot_blocks_all: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && blk == BLK_SLOT) |=> (!take_aerr && !take_irq));
  // R3: no interrupt right after a register transfer
  a_r3_regxf_blocks_irq: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && blk == BLK_NOIRQ) |=> !take_irq);
  // R6: never both at once
  a_r6_single_take: assert property (@(posedge clk) disable iff (rst)
    !(take_aerr && take_irq));
  // R7: a take follows a valid decode
  a_r7_take_needs_decode: assert property (@(posedge clk) disable iff (rst)
    (take_aerr || take_irq) |-> $past(dec_valid));
  // R9: level is zero when no interrupt is taken
  a_r9_level_quiet: assert property (@(posedge clk) disable iff (rst)
    !take_irq |-> (take_level == '0));
endmodule

// File: tb/exc_accept_gate_tb.sv
module exc_accept_gate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LVL_W = 4;
  localparam int NV = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dec_valid = 1'b0;
  logic [1:0] dec_class = 2'd0;
  logic aerr_req = 1'b0;
  logic irq_req = 1'b0;
  logic [LVL_W-1:0] irq_level = '0;
  logic take_aerr, take_irq, aerr_pending, irq_pending, slot_fault;
  logic [LVL_W-1:0] take_level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_accept_gate #(.LVL_W(LVL_W)) dut_i (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_class(dec_class),
    .aerr_req(aerr_req), .irq_req(irq_req), .irq_level(irq_level),
    .take_aerr(take_aerr), .take_irq(take_irq), .take_level(take_level),
    .aerr_pending(aerr_pending), .irq_pending(irq_pending),
    .slot_fault(slot_fault)
  );

  // {req id, valid, class, aerr, irq, level | ta, ti, tlevel, ap, ip, fault}
  localparam logic [21:0] VEC [NV] = '{
    {4'd7,  1'b0,2'd0,1'b0,1'b0,4'd0, 1'b0,1'b0,4'd0,1'b0,1'b0,1'b0}, // R7 idle
    {4'd9,  1'b1,2'd0,1'b0,1'b1,4'd5, 1'b0,1'b1,4'd5,1'b0,1'b0,1'b0}, // R9 level 5
    {4'd2,  1'b1,2'd1,1'b0,1'b0,4'd0, 1'b0,1'b0,4'd0,1'b0,1'b0,1'b0}, // branch
    {4'd2,  1'b1,2'd0,1'b1,1'b1,4'd3, 1'b0,1'b0,4'd0,1'b1,1'b1,1'b0}, // R2 slot
    {4'd6,  1'b1,2'd0,1'b0,1'b1,4'd3, 1'b1,1'b0,4'd0,1'b0,1'b1,1'b0}, // R6 aerr first
    {4'd6,  1'b1,2'd0,1'b0,1'b1,4'd3, 1'b0,1'b1,4'd3,1'b0,1'b0,1'b0}, // R6 irq next
    {4'd3,  1'b1,2'd2,1'b0,1'b0,4'd0, 1'b0,1'b0,4'd0,1'b0,1'b0,1'b0}, // reg xfer
    {4'd7,  1'b0,2'd0,1'b0,1'b1,4'd7, 1'b0,1'b0,4'd0,1'b0,1'b1,1'b0}, // R7 idle in window
    {4'd3,  1'b1,2'd0,1'b0,1'b1,4'd7, 1'b0,1'b0,4'd0,1'b0,1'b1,1'b0}, // R3 irq blocked
    {4'd3,  1'b1,2'd0,1'b0,1'b1,4'd7, 1'b0,1'b1,4'd7,1'b0,1'b0,1'b0}, // R3 released
    {4'd3,  1'b1,2'd2,1'b0,1'b0,4'd0, 1'b0,1'b0,4'd0,1'b0,1'b0,1'b0}, // reg xfer
    {4'd3,  1'b1,2'd0,1'b1,1'b1,4'd2, 1'b1,1'b0,4'd0,1'b0,1'b1,1'b0}, // R3 aerr passes
    {4'd10, 1'b1,2'd2,1'b0,1'b1,4'd2, 1'b0,1'b1,4'd2,1'b0,1'b0,1'b0}, // R10 taken at xfer
    {4'd10, 1'b1,2'd0,1'b0,1'b1,4'd4, 1'b0,1'b1,4'd4,1'b0,1'b0,1'b0}, // R10 no shadow
    {4'd5,  1'b1,2'd1,1'b0,1'b0,4'd0, 1'b0,1'b0,4'd0,1'b0,1'b0,1'b0}, // branch
    {4'd5,  1'b1,2'd0,1'b0,1'b1,4'd6, 1'b0,1'b0,4'd0,1'b0,1'b1,1'b0}, // slot, irq waits
    {4'd5,  1'b0,2'd0,1'b0,1'b0,4'd0, 1'b0,1'b0,4'd0,1'b0,1'b0,1'b0}, // R5 released
    {4'd5,  1'b1,2'd0,1'b0,1'b0,4'd0, 1'b0,1'b0,4'd0,1'b0,1'b0,1'b0}, // R5 nothing taken
    {4'd8,  1'b1,2'd1,1'b0,1'b0,4'd0, 1'b0,1'b0,4'd0,1'b0,1'b0,1'b0}, // branch
    {4'd8,  1'b1,2'd1,1'b0,1'b0,4'd0, 1'b0,1'b0,4'd0,1'b0,1'b0,1'b1}, // R8 fault
    {4'd8,  1'b1,2'd3,1'b1,1'b0,4'd0, 1'b1,1'b0,4'd0,1'b0,1'b0,1'b0}, // R8 unblocked
    {4'd4,  1'b0,2'd0,1'b1,1'b0,4'd0, 1'b0,1'b0,4'd0,1'b1,1'b0,1'b0}, // R4 latched
    {4'd4,  1'b0,2'd0,1'b0,1'b0,4'd0, 1'b0,1'b0,4'd0,1'b1,1'b0,1'b0}, // R4 held
    {4'd4,  1'b1,2'd0,1'b0,1'b0,4'd0, 1'b1,1'b0,4'd0,1'b0,1'b0,1'b0}  // R4 taken
  };

  function automatic logic [8:0] outs();
    return {take_aerr, take_irq, take_level, aerr_pending, irq_pending, slot_fault};
  endfunction

  task automatic check(input int rq, input string what, input logic [8:0] exp);
    checks++;
    if (outs() !== exp) begin
      errors++;
      $display("FAIL R%0d %s: got %b expected %b (ta ti lvl ap ip flt)",
               rq, what, outs(), exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] c, input logic a,
                       input logic i, input logic [LVL_W-1:0] l);
    dec_valid = v; dec_class = c; aerr_req = a; irq_req = i; irq_level = l;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1, "outputs in reset", 9'b0);   // R1
    rst = 1'b0;
    for (int k = 0; k < NV; k++) begin
      drive(VEC[k][17], VEC[k][16:15], VEC[k][14], VEC[k][13], VEC[k][12:9]);
      @(negedge clk);
      check(int'(VEC[k][21:18]), $sformatf("vector %0d", k), VEC[k][8:0]);
    end
    // R1: reset in the middle of a slot with both requests waiting
    drive(1, 2'd1, 0, 0, 0); @(negedge clk);
    drive(1, 2'd0, 1, 1, 1); @(negedge clk);
    check(2, "slot pends both", 9'b0_0_0000_1_1_0);
    drive(0, 2'd0, 0, 0, 0); rst = 1'b1; @(negedge clk);
    check(1, "reset clears pending", 9'b0);
    rst = 1'b0;
    drive(1, 2'd0, 0, 1, 4'd9); @(negedge clk);
    check(1, "first decode after reset unblocked", 9'b0_1_1001_0_0_0);
    // R7: take is a single pulse even while request stays high without decode
    drive(0, 2'd0, 0, 1, 4'd9); @(negedge clk);
    check(7, "pulse ends", 9'b0_0_0000_0_1_0);
    drive(0, 2'd0, 0, 0, 0); @(negedge clk);
    check(5, "idle released", 9'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule